// File: doc/BRIEF.md
# Serial-Loaded Net Override Chain

This block gives test equipment direct control over a set of internal nets that are otherwise hard to drive. Each selected net is cut in two: its source side enters the block and its destination side is driven by the block through a two-input selector. In functional operation the selector passes the source value straight through, with no register in that path. In test operation the selector instead forwards a value held in a dedicated storage flop, one flop per net.

The storage flops are linked into a single shift register. A serial control pin feeds the cell that drives destination net 0. While the shift-enable is high, every clock moves each stored bit one cell toward the far end. While it is low, the register holds, so a loaded pattern stays steady while it is applied. The far cell's content is brought out on a serial output pin, so several chains can be cascaded and a load can be read back.

Top module: `ctl_inject_chain`

## Requirements
- R1: A clock edge with `rst_n` low (synchronous, active low) clears every storage cell to 0, so that afterwards, with `test_mode` at 1, all of `dst_o` and `ctl_so` read 0.
- R2: With `test_mode` at 0, each `dst_o[i]` equals `src_i[i]` in the same cycle, with no clock edge in between.
- R3: With `test_mode` at 1, each `dst_o[i]` equals the content of storage cell i and does not follow `src_i`.
- R4: On a clock edge with `shift_en` at 1 and `rst_n` high, cell 0 takes `ctl_si` and each cell i above 0 takes the old content of cell i-1.
- R5: On a clock edge with `shift_en` at 0 and `rst_n` high, every cell keeps its content.
- R6: After `NUM_POINTS` consecutive shift clocks, the first bit shifted in sits in cell `NUM_POINTS-1`, the cell that drives the highest-indexed destination.
- R7: `ctl_so` always equals the content of cell `NUM_POINTS-1`, whatever `test_mode` is.
- R8: Shifting while `test_mode` is 0 changes the stored pattern but not `dst_o`, which keeps following `src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage cells |
| rst_n | input | 1 | Synchronous active-low reset of the storage cells |
| test_mode | input | 1 | 0: destinations follow sources; 1: destinations follow storage cells |
| shift_en | input | 1 | 1: advance the chain by one cell per clock; 0: hold |
| ctl_si | input | 1 | Serial control bit entering cell 0 |
| src_i | input | NUM_POINTS | Source sides of the cut nets |
| dst_o | output | NUM_POINTS | Destination sides of the cut nets |
| ctl_so | output | 1 | Content of the last cell, for cascading or readback |

## Verification
The source nets are driven with walking ones, all-ones, all-zeros and alternating patterns in both modes, which separates a selector stuck on one input from one with swapped data inputs, and a combinational pass path from one that lags by a clock. The serial side is loaded with a lone one in a field of zeros and with alternating bits, so a chain that skips, repeats or reverses a cell gives a visibly different pattern. Hold periods with the shift-enable low between loads, shifting while in functional mode, and a reset in the middle of a loaded pattern show whether the stored state moves or clears only when it should.

// File: rtl/cic_pkg.sv
// Package: shared definitions for the net override chain.
// Assumes: the selector control is a single bit, 0 selecting the functional path.
package cic_pkg;

    // Which side drives a destination net.
    typedef enum logic {
        PATH_FUNC = 1'b0,
        PATH_CTRL = 1'b1
    } path_sel_e;

endpackage

// File: rtl/cic_hold_flop.sv
// Module: one storage cell of the chain. Loads d_i when adv is high, holds
// otherwise, clears on a synchronous active-low reset.
// Assumes: clk is free-running; rst_n is synchronous to clk.
module cic_hold_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic d_i,
    output logic q_o
);

    // Storage cell update: reset, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (adv) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/cic_bypass_mux.sv
// Module: two-input selector placed on a cut net. Purely combinational.
// Assumes: sel_ctrl uses the encoding of cic_pkg::path_sel_e.
module cic_bypass_mux
    import cic_pkg::*;
(
    input  logic sel_ctrl,
    input  logic func_i,
    input  logic ctrl_i,
    output logic dst_o
);

    path_sel_e sel;

    assign sel = path_sel_e'(sel_ctrl);

    // Forward the functional value or the stored control value.
    always_comb begin
        case (sel)
            PATH_CTRL: dst_o = ctrl_i;
            default:   dst_o = func_i;
        endcase
    end

endmodule

// File: rtl/ctl_inject_chain.sv
// Module: top of the net override chain. NUM_POINTS cut nets, each with a
// selector and a storage cell; the cells form one serial shift register
// fed at cell 0 and tapped at the last cell.
// Assumes: NUM_POINTS >= 1; inputs are synchronous to clk.
module ctl_inject_chain #(
    parameter int NUM_POINTS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_mode,
    input  logic                  shift_en,
    input  logic                  ctl_si,
    input  logic [NUM_POINTS-1:0] src_i,
    output logic [NUM_POINTS-1:0] dst_o,
    output logic                  ctl_so
);

    localparam int TAP_W = NUM_POINTS + 1;

    // tap[0] is the serial input; tap[i+1] is the content of cell i.
    logic [TAP_W-1:0] tap;

    assign tap[0] = ctl_si;

    // One storage cell and one selector per cut net.
    for (genvar i = 0; i < NUM_POINTS; i++) begin : g_point
        cic_hold_flop u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (shift_en),
            .d_i   (tap[i]),
            .q_o   (tap[i+1])
        );

        cic_bypass_mux u_sel (
            .sel_ctrl (test_mode),
            .func_i   (src_i[i]),
            .ctrl_i   (tap[i+1]),
            .dst_o    (dst_o[i])
        );
    end

    // Serial readback of the far cell.
    assign ctl_so = tap[TAP_W-1];

endmodule

// File: rtl/ctl_inject_chain_chk.sv
// Module: property checker for ctl_inject_chain, observing ports only.
// Assumes: bound to every instance of ctl_inject_chain.
module ctl_inject_chain_chk #(
    parameter int NUM_POINTS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  test_mode,
    input logic                  shift_en,
    input logic                  ctl_si,
    input logic [NUM_POINTS-1:0] src_i,
    input logic [NUM_POINTS-1:0] dst_o,
    input logic                  ctl_so
);

    logic armed;

    // Marks that a reset has been seen, so $past values are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(rst_n) && test_mode) |-> (dst_o == '0 && ctl_so == 1'b0)); // R1

    AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode) |-> (dst_o == src_i)); // R2

    AST_SO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (ctl_so == dst_o[NUM_POINTS-1])); // R7

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n) && $past(shift_en) && test_mode)
            |-> (dst_o[0] == $past(ctl_si))); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n) && !$past(shift_en) && test_mode && $past(test_mode))
            |-> $stable(dst_o)); // R5

    if (NUM_POINTS > 1) begin : g_multi
        AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(rst_n) && $past(shift_en) && test_mode && $past(test_mode))
                |-> (dst_o[NUM_POINTS-1:1] == $past(dst_o[NUM_POINTS-2:0]))); // R4
    end

endmodule

bind ctl_inject_chain ctl_inject_chain_chk #(.NUM_POINTS(NUM_POINTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .shift_en  (shift_en),
    .ctl_si    (ctl_si),
    .src_i     (src_i),
    .dst_o     (dst_o),
    .ctl_so    (ctl_so)
);

// File: tb/tb_ctl_inject_chain.sv
// Bench: behavioural queue model of the chain, compared every clock.
module tb_ctl_inject_chain;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic         shift_en = 1'b0;
    logic         ctl_si = 1'b0;
    logic [N-1:0] src_i = '0;
    logic [N-1:0] dst_o;
    logic         ctl_so;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    bit  model_q[$];

    ctl_inject_chain #(.NUM_POINTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_en(shift_en),
        .ctl_si(ctl_si), .src_i(src_i), .dst_o(dst_o), .ctl_so(ctl_so)
    );

    always #4 clk = ~clk;

    function automatic logic [N-1:0] model_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = model_q[i];
        return v;
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one cycle, compare outputs before the edge, advance the model.
    task automatic step(string req, logic rn, logic tm, logic se, logic si, logic [N-1:0] src);
        rst_n = rn; test_mode = tm; shift_en = se; ctl_si = si; src_i = src;
        #1;
        check_vec(req, dst_o, tm ? model_vec() : src);
        check_bit({req, "/R7"}, ctl_so, model_q[N-1]);
        @(posedge clk);
        if (!rn) begin
            foreach (model_q[i]) model_q[i] = 1'b0;
        end else if (se) begin
            model_q.push_front(si);
            void'(model_q.pop_back());
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) model_q.push_back(1'b0);
        @(negedge clk);
        // R1: synchronous reset
        rst_n = 1'b0; test_mode = 1'b1;
        @(posedge clk); @(negedge clk);
        step("R1 reset", 1'b0, 1'b1, 1'b1, 1'b1, 3'b111);
        check_vec("R1 cleared", dst_o, '0);
        step("R1 after", 1'b1, 1'b1, 1'b0, 1'b0, 3'b101);
        // R2: functional pass-through, several patterns
        step("R2 walk1", 1'b1, 1'b0, 1'b0, 1'b0, 3'b001);
        step("R2 walk2", 1'b1, 1'b0, 1'b0, 1'b0, 3'b010);
        step("R2 walk3", 1'b1, 1'b0, 1'b0, 1'b0, 3'b100);
        step("R2 ones",  1'b1, 1'b0, 1'b0, 1'b0, 3'b111);
        step("R2 alt",   1'b1, 1'b0, 1'b0, 1'b0, 3'b101);
        // R4/R6: load a lone one with test_mode high
        step("R4 shift", 1'b1, 1'b1, 1'b1, 1'b1, 3'b000);
        step("R4 shift", 1'b1, 1'b1, 1'b1, 1'b0, 3'b111);
        step("R4 shift", 1'b1, 1'b1, 1'b1, 1'b0, 3'b010);
        check_vec("R6 first bit at far cell", dst_o, 3'b100);
        check_bit("R7 so", ctl_so, 1'b1);
        // R5/R3: hold while sources toggle
        for (int k = 0; k < 4; k++)
            step("R5 hold/R3 ignore src", 1'b1, 1'b1, 1'b0, ~ctl_si, 3'(k * 3));
        check_vec("R5 held", dst_o, 3'b100);
        // R8: shift alternating bits while in functional mode
        step("R8 shift func", 1'b1, 1'b0, 1'b1, 1'b1, 3'b011);
        step("R8 shift func", 1'b1, 1'b0, 1'b1, 1'b0, 3'b110);
        step("R8 shift func", 1'b1, 1'b0, 1'b1, 1'b1, 3'b001);
        step("R3 apply", 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
        check_vec("R3 loaded alt", dst_o, 3'b101);
        step("R4 more", 1'b1, 1'b1, 1'b1, 1'b0, 3'b000);
        step("R4 more", 1'b1, 1'b1, 1'b1, 1'b1, 3'b111);
        step("R4 more", 1'b1, 1'b1, 1'b0, 1'b0, 3'b111);
        // R1: reset in mid-pattern
        step("R1 mid reset", 1'b0, 1'b1, 1'b0, 1'b1, 3'b111);
        step("R1 post", 1'b1, 1'b1, 1'b0, 1'b0, 3'b111);
        check_vec("R1 mid cleared", dst_o, '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule